// File: doc/BRIEF.md
# Interrupt Pending Aggregator with Vector Lookup

This block collects a fixed set of interrupt sources and drives a single interrupt request line toward a processor. Every source has a level input, a constant vector code and a constant coverage mask that states which of the shared enable bits gate it. A source counts as pending only when its level is asserted and every enable bit in its coverage mask is set. A source is also reserved if it has a zero vector code, or if it is an ordinary source with an empty coverage mask. The enable bits come from a separate register bank as a plain vector. The request line is driven from a count of the pending sources.

The top sources in the index range form a priority chain. These sources are driven from a 4-bit encoded level input, not from their own level pins. The level code is XORed with 15 to give a chain position. The source at that position is asserted and forced enabled, and every other chain source is deasserted. When the processor strobes a vector request, the block returns the vector of the lowest-indexed pending source. It returns no vector when the processor's mask level is 15 or when nothing is pending.

The request line is held by a two-state machine. In IRQ_QUIET the line is low. The transition QUIET to RAISED is taken when the pending count becomes nonzero. In IRQ_RAISED the line is high. The transition RAISED to QUIET is taken when the count returns to zero.

Top module: `irq_pend_agg`

## Requirements
- R1: An ordinary source is enabled only when the number of its set covering enable bits equals the number of bits in its coverage mask, so every covering bit must be set. With the default parameters, source 0 is covered by enable bits 0 and 1, source 1 by bits 1 and 2, and source 2 by bit 3.
- R2: A source is pending when it is asserted, enabled and not reserved. A change on the level, enable or level-code inputs reaches `irq` after the second rising clock edge.
- R3: `irq` is high exactly while the registered pending count is nonzero. It rises when the count leaves 0 and falls when the count returns to 0.
- R4: A level input that already matches the stored assertion state of its source changes nothing. A held-high source keeps `irq` high over many cycles.
- R5: A vector request returns, one edge later, `vec_valid`=1 and the vector of the lowest-indexed pending source. The default vectors are 0x200, 0x220, 0x000, 0x260, 0x300, 0x320, 0x340 and 0x360 for sources 0 to 7.
- R6: A vector request made while `imask` equals 15 returns `vec_valid`=0 and `vec_code`=0.
- R7: A vector request made while no source is pending returns `vec_valid`=0 and `vec_code`=0.
- R8: The chain is sources 4 to 7 by default. Level code L selects chain position L XOR 15, so 15 selects source 4, 14 selects source 5, 13 selects source 6 and 12 selects source 7. Only that chain source is asserted. Codes 0 to 11 assert no chain source, and the chain sources' own level pins are ignored.
- R9: The selected chain source is pending regardless of the enable bits.
- R10: A reserved source is never pending. With the default parameters, source 2 is reserved by its zero vector and source 3 by its empty mask.
- R11: A synchronous reset clears the assertion state, the pending count, `irq` and the vector response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_lvl | input | NUM_SRC | Level input per source (chain entries unused) |
| en_bits | input | NUM_EN | Enable bits from the register bank |
| lvl_code | input | 4 | Encoded priority level for the chain |
| vreq | input | 1 | Vector request strobe |
| imask | input | 4 | Processor interrupt mask level |
| irq | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Last vector response holds a vector |
| vec_code | output | VEC_W | Last returned vector, 0 if none |

## Verification
A change on the level, enable or level-code inputs is captured at the first clock edge and reaches `irq` at the second. A vector request reads the pending state registered at the edge that samples the request, so its response appears one edge after the request. The bench drives all inputs on falling edges. It waits two rising edges after a stimulus before it raises `vreq`, then waits one more edge and samples on the falling edge. A directed test also checks that `irq` is still low after only one edge, which confirms the two-edge latency.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

    localparam logic [3:0] MASK_ALL = 4'hF;
endpackage

// File: rtl/irqagg_slot.sv
module irqagg_slot #(
    parameter int                  NUM_EN   = 6,
    parameter int                  VEC_W    = 12,
    parameter logic [VEC_W-1:0]    VEC      = '0,
    parameter logic [NUM_EN-1:0]   COVER    = '0,
    parameter bit                  IS_CHAIN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl_in,
    input  logic [NUM_EN-1:0] en_bits,
    input  logic              chain_hit,
    output logic              pend
);
    localparam int REQ_CNT  = $countones(COVER);
    localparam bit RESERVED = (VEC == '0) || (!IS_CHAIN && REQ_CNT == 0);

    logic asrt_q;
    logic en_ok_q;
    logic lvl_eff;
    logic en_eff;

    always_comb begin
        lvl_eff = IS_CHAIN ? chain_hit : lvl_in;
        en_eff  = IS_CHAIN ? chain_hit
                           : ($countones(en_bits & COVER) == REQ_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asrt_q  <= 1'b0;
            en_ok_q <= 1'b0;
        end else begin
            if (lvl_eff != asrt_q) asrt_q <= lvl_eff;
            en_ok_q <= en_eff;
        end
    end

    assign pend = asrt_q & en_ok_q & !RESERVED;

    // R4: a level equal to the stored state leaves it untouched
    assert_edge_only_R4: assert property (@(posedge clk) disable iff (rst)
        (!IS_CHAIN && lvl_in == asrt_q) |=> $stable(asrt_q));

    // R10: reserved sources stay quiet
    assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        RESERVED |-> !pend);
endmodule

// File: rtl/irqagg_lvl_dec.sv
module irqagg_lvl_dec #(
    parameter int CHAIN_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           code,
    output logic [CHAIN_LEN-1:0] hit
);
    logic [3:0] pos;

    always_comb begin
        pos = code ^ 4'hF;
        for (int i = 0; i < CHAIN_LEN; i++)
            hit[i] = (pos == 4'(i));
    end

    // R8: at most one chain source selected
    assert_one_hot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    // R8: code 0 selects nothing
    assert_zero_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (code == 4'h0) |-> (hit == '0));
endmodule

// File: rtl/irqagg_pick.sv
module irqagg_pick #(
    parameter int                       NUM_SRC = 8,
    parameter int                       VEC_W   = 12,
    parameter logic [NUM_SRC*VEC_W-1:0] VECS    = '0
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               any,
    output logic [VEC_W-1:0]   code
);
    always_comb begin
        any  = 1'b0;
        code = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any  = 1'b1;
                code = VECS[i*VEC_W +: VEC_W];
            end
        end
    end
endmodule

// File: rtl/irq_pend_agg.sv
module irq_pend_agg #(
    parameter int                        NUM_SRC   = 8,
    parameter int                        NUM_EN    = 6,
    parameter int                        VEC_W     = 12,
    parameter int                        CHAIN_LEN = 4,
    parameter logic [NUM_SRC*VEC_W-1:0]  VECS  = {12'h360, 12'h340, 12'h320, 12'h300,
                                                  12'h260, 12'h000, 12'h220, 12'h200},
    parameter logic [NUM_SRC*NUM_EN-1:0] COVER = {6'd0, 6'd0, 6'd0, 6'd0,
                                                  6'd0, 6'b001000, 6'b000110, 6'b000011}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_EN-1:0]  en_bits,
    input  logic [3:0]         lvl_code,
    input  logic               vreq,
    input  logic [3:0]         imask,
    output logic               irq,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_code
);
    import irqagg_pkg::*;

    localparam int CHAIN_BASE = NUM_SRC - CHAIN_LEN;
    localparam int CNT_W      = $clog2(NUM_SRC + 1);

    logic [CHAIN_LEN-1:0] chain_hit;
    logic [NUM_SRC-1:0]   pend;
    logic [NUM_SRC-1:0]   pend_q;
    logic [CNT_W-1:0]     cnt_d, cnt_q;
    logic                 pick_any;
    logic [VEC_W-1:0]     pick_code;
    irq_state_t           state_q, state_d;

    irqagg_lvl_dec #(.CHAIN_LEN(CHAIN_LEN)) u_dec (
        .clk(clk), .rst(rst), .code(lvl_code), .hit(chain_hit)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        logic hit_g;
        if (g >= CHAIN_BASE) begin : g_chain
            assign hit_g = chain_hit[g - CHAIN_BASE];
        end else begin : g_plain
            assign hit_g = 1'b0;
        end
        irqagg_slot #(
            .NUM_EN(NUM_EN), .VEC_W(VEC_W),
            .VEC(VECS[g*VEC_W +: VEC_W]),
            .COVER(COVER[g*NUM_EN +: NUM_EN]),
            .IS_CHAIN(g >= CHAIN_BASE)
        ) u_slot (
            .clk(clk), .rst(rst), .lvl_in(src_lvl[g]), .en_bits(en_bits),
            .chain_hit(hit_g), .pend(pend[g])
        );
    end

    irqagg_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VECS(VECS)) u_pick (
        .pend(pend_q), .any(pick_any), .code(pick_code)
    );

    assign cnt_d = CNT_W'($countones(pend));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (cnt_d != '0) state_d = IRQ_RAISED;
            IRQ_RAISED: if (cnt_d == '0) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IRQ_QUIET;
            pend_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_code  <= '0;
        end else if (vreq) begin
            if (imask == MASK_ALL || !pick_any) begin
                vec_valid <= 1'b0;
                vec_code  <= '0;
            end else begin
                vec_valid <= 1'b1;
                vec_code  <= pick_code;
            end
        end
    end

    always_comb irq = (state_q == IRQ_RAISED);

    assert_irq_count_R3: assert property (@(posedge clk) disable iff (rst)
        irq == (cnt_q != '0));

    assert_masked_none_R6: assert property (@(posedge clk) disable iff (rst)
        (vreq && imask == MASK_ALL) |=> (!vec_valid && vec_code == '0));

    assert_idle_none_R7: assert property (@(posedge clk) disable iff (rst)
        (vreq && pend_q == '0) |=> (!vec_valid && vec_code == '0));

    assert_valid_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_code != '0));
endmodule

// File: tb/sim_irq_pend_agg.sv
`timescale 1ns/1ps
module sim_irq_pend_agg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  src_lvl = '0;
    logic [5:0]  en_bits = '0;
    logic [3:0]  lvl_code = '0;
    logic        vreq = 1'b0;
    logic [3:0]  imask = '0;
    logic        irq, vec_valid;
    logic [11:0] vec_code;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_pend_agg u0 (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .en_bits(en_bits),
        .lvl_code(lvl_code), .vreq(vreq), .imask(imask),
        .irq(irq), .vec_valid(vec_valid), .vec_code(vec_code)
    );

    // row: {src 8, en 6, lvl 4, imask 4, irq 1, valid 1, code 12} = 36 bits
    localparam int ROWS = 11;
    localparam logic [35:0] TBL [ROWS] = '{
        {8'h01, 6'h03, 4'd0,  4'd0,  1'b1, 1'b1, 12'h200}, // R1 R5 both bits set
        {8'h01, 6'h01, 4'd0,  4'd0,  1'b0, 1'b0, 12'h000}, // R1 R7 one bit missing
        {8'h03, 6'h06, 4'd0,  4'd0,  1'b1, 1'b1, 12'h220}, // R1 only src1 enabled
        {8'h03, 6'h07, 4'd0,  4'd0,  1'b1, 1'b1, 12'h200}, // R5 lowest wins
        {8'h0C, 6'h3F, 4'd0,  4'd0,  1'b0, 1'b0, 12'h000}, // R10 reserved pair
        {8'h00, 6'h00, 4'd15, 4'd0,  1'b1, 1'b1, 12'h300}, // R8 R9 level 15
        {8'h00, 6'h00, 4'd12, 4'd0,  1'b1, 1'b1, 12'h360}, // R8 level 12
        {8'hF0, 6'h3F, 4'd5,  4'd0,  1'b0, 1'b0, 12'h000}, // R8 no chain hit
        {8'h02, 6'h06, 4'd13, 4'd15, 1'b1, 1'b0, 12'h000}, // R6 mask 15
        {8'h02, 6'h06, 4'd13, 4'd14, 1'b1, 1'b1, 12'h220}, // R5 below chain
        {8'h00, 6'h00, 4'd0,  4'd0,  1'b0, 1'b0, 12'h000}  // R8 code 0 clears
    };

    function automatic string row_tag(int r);
        case (r)
            0, 1, 2: return "R1";
            3, 9:    return "R5";
            4:       return "R10";
            5:       return "R9";
            8:       return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [7:0] s, logic [5:0] e, logic [3:0] l, logic [3:0] m);
        @(negedge clk);
        src_lvl = s; en_bits = e; lvl_code = l; imask = m;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ask();
        vreq = 1'b1;
        @(posedge clk);
        @(negedge clk);
        vreq = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk("R11 irq after reset", {11'd0, irq}, 12'd0);
        ask();
        chk("R11 valid after reset", {11'd0, vec_valid}, 12'd0);
        chk("R7 code when idle", vec_code, 12'd0);

        for (int r = 0; r < ROWS; r++) begin
            drive(TBL[r][35:28], TBL[r][27:22], TBL[r][21:18], TBL[r][17:14]);
            chk({row_tag(r), " irq"}, {11'd0, irq}, {11'd0, TBL[r][13]});
            ask();
            chk({row_tag(r), " valid"}, {11'd0, vec_valid}, {11'd0, TBL[r][12]});
            chk({row_tag(r), " code"}, vec_code, TBL[r][11:0]);
        end

        // R2: latency, still low after one edge, high after two
        @(negedge clk);
        src_lvl = 8'h01; en_bits = 6'h03;
        @(posedge clk);
        @(negedge clk);
        chk("R2 irq one edge", {11'd0, irq}, 12'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 irq two edges", {11'd0, irq}, 12'd1);

        // R4: held level keeps state
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R4 irq held", {11'd0, irq}, 12'd1);

        // R3: count falls through 2 -> 1 -> 0
        drive(8'h03, 6'h07, 4'd0, 4'd0);
        drive(8'h02, 6'h07, 4'd0, 4'd0);
        chk("R3 irq one left", {11'd0, irq}, 12'd1);
        drive(8'h00, 6'h07, 4'd0, 4'd0);
        chk("R3 irq none left", {11'd0, irq}, 12'd0);

        // R9: enables cleared, chain source still raises
        drive(8'h00, 6'h00, 4'd14, 4'd0);
        ask();
        chk("R9 chain forced", vec_code, 12'h320);

        // R11: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 irq in reset", {11'd0, irq}, 12'd0);
        chk("R11 valid in reset", {11'd0, vec_valid}, 12'd0);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule